// File: doc/BRIEF.md
# Two-Way Inter-Processor Word Mailbox

This block links two processors, side A and side B, through a pair of 32-bit word queues. Each queue carries traffic in one direction only. Whatever side A writes to its send port, side B later reads from its receive port, in the same order, and the reverse also holds. Each side sees its own small register window: a handshake (sync) register, a control/status register, a write-only send port and a read-only receive port. The receive port sits far above the other three, at offset 0x100000.

Each side's control register holds an enable bit and its status flags. That enable bit gates both the side's own sends and the side's own reads. While a side is disabled, its sends are dropped and its reads return the queue head without removing it. Reading an empty queue gives zero and leaves a sticky flag. Pushing into a full queue changes nothing and leaves another sticky flag. The sync register lets each side publish a 4-bit value that the other side can read. Its lowest nibble is protected against writes.

Registers are read with one cycle of latency. A read strobe in cycle t yields data on the read-data port from the following cycle, and that data holds until the next read. The reset is synchronous and active high.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty and both sync registers read 0x00000000. Each control register reads 0x00000005: bit 0 is "own send queue empty", bit 2 is "own receive queue empty", and every other bit is 0.
- R2: A word written at offset 0x188 by one side is returned by a read at offset 0x100000 on the other side. Words come out in the order they were written. The read data appears on the side's read-data port in the cycle after the read strobe.
- R3: Each queue holds 16 words. With 16 words held, the sender's control bit 1 (send full) and the receiver's control bit 3 (receive full) read 1.
- R4: While the sender's enable bit (control bit 15) is 0, a write to the send port leaves the queue unchanged.
- R5: While the reader's enable bit is 0, a read of the receive port returns the head word and does not remove it.
- R6: A read of the receive port while its queue is empty returns 0x00000000 and sets control bit 8. The flag stays set until the side writes its control register with bit 8 = 1.
- R7: A send while the queue is full and the sender is enabled leaves the queue contents unchanged and sets control bit 14. Writing the control register with bit 14 = 1 clears the flag.
- R8: Sync register bits 3:0 always read 0. A write never changes them.
- R9: Sync bits 15:12 and 7:4 take the written data. Bits 11:8 are read-only and show the other side's sync bits 7:4.
- R10: With the enable bit at 1, a read of a non-empty receive port removes the head word, so the next read returns the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 21 | Side A register offset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| b_addr | input | 21 | Side B register offset |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |

## Verification
Short bursts in both directions at once show that the queues are cross-wired and keep order, rather than looping back to the sender. A full fill of 16 distinct words followed by a 17th separates a correct depth and overflow guard from an off-by-one pointer compare. Repeated reads with the reader disabled, then with it enabled, tell a peek apart from a pop. A sync write of all ones from one side and of a mixed pattern from the other shows that the protected nibble holds and that the remote nibble lands in the right bits.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 21;
  localparam int QDEPTH = 16;

  localparam logic [ADDR_W-1:0] OFF_SYNC = 21'h000180;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 21'h000184;
  localparam logic [ADDR_W-1:0] OFF_SEND = 21'h000188;
  localparam logic [ADDR_W-1:0] OFF_RECV = 21'h100000;

  // control bit positions
  localparam int CB_TX_EMPTY = 0;
  localparam int CB_TX_FULL  = 1;
  localparam int CB_RX_EMPTY = 2;
  localparam int CB_RX_FULL  = 3;
  localparam int CB_UNDERRUN = 8;
  localparam int CB_OVERRUN  = 14;
  localparam int CB_ENABLE   = 15;

  typedef struct packed {
    logic tx_empty;
    logic tx_full;
    logic rx_empty;
    logic rx_full;
    logic underrun;
    logic overrun;
    logic enable;
  } ctrl_view_t;

  function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_view_t v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CB_TX_EMPTY] = v.tx_empty;
    w[CB_TX_FULL]  = v.tx_full;
    w[CB_RX_EMPTY] = v.rx_empty;
    w[CB_RX_FULL]  = v.rx_full;
    w[CB_UNDERRUN] = v.underrun;
    w[CB_OVERRUN]  = v.overrun;
    w[CB_ENABLE]   = v.enable;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] sync_word(input logic [3:0] hi,
                                                  input logic [3:0] remote,
                                                  input logic [3:0] own);
    return {16'h0000, hi, remote, own, 4'h0};
  endfunction

endpackage

// File: rtl/ipc_word_queue.sv
module ipc_word_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [WIDTH-1:0]         push_data,
  input  logic                     pop,
  output logic [WIDTH-1:0]         head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   wr_count,
  output logic [$clog2(DEPTH):0]   rd_count
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  function automatic logic [PTR_W-1:0] fill_of(input logic [PTR_W-1:0] w,
                                               input logic [PTR_W-1:0] r);
    return w - r;
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [PTR_W-1:0] p);
    return p[IDX_W-1:0];
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W-1:0] level;
  logic             push_ok, pop_ok;

  assign level   = fill_of(wp, rp);
  assign empty   = (wp == rp);
  assign full    = (level == PTR_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[slot_of(rp)];
  assign wr_count = wp;
  assign rd_count = rp;

  always_ff @(posedge clk) begin
    if (push_ok) mem[slot_of(wp)] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
    end
  end

  // R3: fill level never exceeds the depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    level <= PTR_W'(DEPTH));

  // R7: a push into a full queue never advances the write pointer
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (full && push) |=> $stable(wr_count));

endmodule

// File: rtl/ipc_cpu_port.sv
module ipc_cpu_port
  import ipc_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              tx_push,
  output logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  input  logic              tx_full,
  output logic              rx_pop,
  input  logic [WORD_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic [3:0]        remote_nib,
  output logic [3:0]        own_nib,
  output logic              enable
);
  logic sel_sync, sel_ctrl, sel_send, sel_recv;
  logic ctrl_wr, sync_wr;
  logic empty_hit, full_hit;
  logic underrun, overrun;
  logic [3:0] sync_hi;
  ctrl_view_t view;

  assign sel_sync = (addr == OFF_SYNC);
  assign sel_ctrl = (addr == OFF_CTRL);
  assign sel_send = (addr == OFF_SEND);
  assign sel_recv = (addr == OFF_RECV);

  assign ctrl_wr   = wr && sel_ctrl;
  assign sync_wr   = wr && sel_sync;
  assign tx_push   = wr && sel_send && enable && !tx_full;
  assign full_hit  = wr && sel_send && enable && tx_full;
  assign tx_data   = wdata;
  assign rx_pop    = rd && sel_recv && enable && !rx_empty;
  assign empty_hit = rd && sel_recv && rx_empty;

  always_comb begin
    view.tx_empty = tx_empty;
    view.tx_full  = tx_full;
    view.rx_empty = rx_empty;
    view.rx_full  = rx_full;
    view.underrun = underrun;
    view.overrun  = overrun;
    view.enable   = enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      underrun <= 1'b0;
      overrun  <= 1'b0;
      sync_hi  <= '0;
      own_nib  <= '0;
    end else begin
      if (ctrl_wr) enable <= wdata[CB_ENABLE];
      underrun <= empty_hit || (underrun && !(ctrl_wr && wdata[CB_UNDERRUN]));
      overrun  <= full_hit  || (overrun  && !(ctrl_wr && wdata[CB_OVERRUN]));
      if (sync_wr) begin
        sync_hi <= wdata[15:12];
        own_nib <= wdata[7:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (sel_sync)      rdata <= sync_word(sync_hi, remote_nib, own_nib);
      else if (sel_ctrl) rdata <= ctrl_word(view);
      else if (sel_recv) rdata <= rx_empty ? '0 : rx_head;
      else               rdata <= '0;
    end
  end

  // R6: an empty read yields zero and leaves the underrun flag set
  p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    empty_hit |=> (rdata == '0) && underrun);

  // R7: a rejected send leaves the overrun flag set
  p_overrun_flag_r7: assert property (@(posedge clk) disable iff (rst)
    full_hit |=> overrun);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata
);
  localparam int NSIDE = 2;
  localparam int CNT_W = $clog2(QDEPTH) + 1;

  logic [ADDR_W-1:0] addr_v  [NSIDE];
  logic              wr_v    [NSIDE];
  logic              rd_v    [NSIDE];
  logic [WORD_W-1:0] wdata_v [NSIDE];
  logic [WORD_W-1:0] rdata_v [NSIDE];

  // queue i is filled by side i and drained by the other side
  logic              q_push  [NSIDE];
  logic [WORD_W-1:0] q_data  [NSIDE];
  logic              q_pop   [NSIDE];
  logic [WORD_W-1:0] q_head  [NSIDE];
  logic              q_empty [NSIDE];
  logic              q_full  [NSIDE];
  logic [CNT_W-1:0]  q_wcnt  [NSIDE];
  logic [CNT_W-1:0]  q_rcnt  [NSIDE];
  logic [3:0]        nib     [NSIDE];
  logic              en      [NSIDE];

  assign addr_v[0] = a_addr;  assign addr_v[1] = b_addr;
  assign wr_v[0]   = a_wr;    assign wr_v[1]   = b_wr;
  assign rd_v[0]   = a_rd;    assign rd_v[1]   = b_rd;
  assign wdata_v[0] = a_wdata; assign wdata_v[1] = b_wdata;
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    localparam int PEER = NSIDE - 1 - i;

    ipc_word_queue #(.DEPTH(QDEPTH), .WIDTH(WORD_W)) u_queue (
      .clk(clk), .rst(rst),
      .push(q_push[i]), .push_data(q_data[i]), .pop(q_pop[i]),
      .head(q_head[i]), .empty(q_empty[i]), .full(q_full[i]),
      .wr_count(q_wcnt[i]), .rd_count(q_rcnt[i])
    );

    ipc_cpu_port u_port (
      .clk(clk), .rst(rst),
      .addr(addr_v[i]), .wr(wr_v[i]), .rd(rd_v[i]),
      .wdata(wdata_v[i]), .rdata(rdata_v[i]),
      .tx_push(q_push[i]), .tx_data(q_data[i]),
      .tx_empty(q_empty[i]), .tx_full(q_full[i]),
      .rx_pop(q_pop[PEER]), .rx_head(q_head[PEER]),
      .rx_empty(q_empty[PEER]), .rx_full(q_full[PEER]),
      .remote_nib(nib[PEER]), .own_nib(nib[i]), .enable(en[i])
    );

    // R4: a disabled sender never moves its queue's write pointer
    p_send_ignored_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_v[i] && addr_v[i] == OFF_SEND && !en[i]) |=> $stable(q_wcnt[i]));

    // R5: a disabled reader never moves the peer queue's read pointer
    p_peek_keeps_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_v[i] && addr_v[i] == OFF_RECV && !en[i]) |=> $stable(q_rcnt[PEER]));
  end

endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  import ipc_mailbox_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
  logic [WORD_W-1:0] a_wdata = '0, b_wdata = '0;
  logic [WORD_W-1:0] a_rdata, b_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_wr(b_wr), .b_rd(b_rd), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG_CYCLES && !finished) begin
      finished = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FIFO watchdog expired: FAIL R1 actual=hang expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // side 0 = A, side 1 = B
  task automatic reg_write(input int side, input logic [ADDR_W-1:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin a_addr = ad; a_wdata = d; a_wr = 1'b1; end
    else           begin b_addr = ad; b_wdata = d; b_wr = 1'b1; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic reg_read(input int side, input logic [ADDR_W-1:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin a_addr = ad; a_rd = 1'b1; end
    else           begin b_addr = ad; b_rd = 1'b1; end
    @(negedge clk);
    a_rd = 1'b0; b_rd = 1'b0;
    d = (side == 0) ? a_rdata : b_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(0, OFF_CTRL, v); check("R1 A ctrl", v, 32'h5);
    reg_read(1, OFF_CTRL, v); check("R1 B ctrl", v, 32'h5);
    reg_read(0, OFF_SYNC, v); check("R1 A sync", v, 32'h0);
    reg_read(1, OFF_SYNC, v); check("R1 B sync", v, 32'h0);
  endtask

  task automatic t_cross();
    logic [31:0] v;
    reg_write(0, OFF_CTRL, 32'h8000);
    reg_write(1, OFF_CTRL, 32'h8000);
    for (int k = 0; k < 3; k++) reg_write(0, OFF_SEND, 32'hA000_0000 + k);
    for (int k = 0; k < 2; k++) reg_write(1, OFF_SEND, 32'hB000_0000 + k);
    for (int k = 0; k < 3; k++) begin
      reg_read(1, OFF_RECV, v); check("R2 R10 B receives A in order", v, 32'hA000_0000 + k);
    end
    for (int k = 0; k < 2; k++) begin
      reg_read(0, OFF_RECV, v); check("R2 R10 A receives B in order", v, 32'hB000_0000 + k);
    end
    reg_read(1, OFF_CTRL, v); check("R10 B ctrl after drain", v, 32'h8005);
  endtask

  task automatic t_fill();
    logic [31:0] v;
    for (int k = 0; k < QDEPTH; k++) reg_write(0, OFF_SEND, 32'h1234_0000 + k);
    reg_read(0, OFF_CTRL, v); check("R3 A send full", v, 32'h8006);
    reg_read(1, OFF_CTRL, v); check("R3 B receive full", v, 32'h8009);
    reg_write(0, OFF_SEND, 32'hDEAD_BEEF);
    reg_read(0, OFF_CTRL, v); check("R7 overrun flag set", v, 32'hC006);
    for (int k = 0; k < QDEPTH; k++) begin
      reg_read(1, OFF_RECV, v); check("R3 R7 fill order intact", v, 32'h1234_0000 + k);
    end
    reg_read(1, OFF_RECV, v); check("R7 rejected word absent", v, 32'h0);
    reg_write(1, OFF_CTRL, 32'h8100);
    reg_write(0, OFF_CTRL, 32'hC000);
    reg_read(0, OFF_CTRL, v); check("R7 overrun flag cleared", v, 32'h8005);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    reg_write(0, OFF_CTRL, 32'h0000);
    reg_write(0, OFF_SEND, 32'h5555_0001);
    reg_read(1, OFF_CTRL, v); check("R4 disabled send dropped", v, 32'h8005);
    reg_write(0, OFF_CTRL, 32'h8000);
    reg_write(0, OFF_SEND, 32'h5555_0002);
    reg_write(1, OFF_CTRL, 32'h0000);
    reg_read(1, OFF_RECV, v); check("R5 peek first", v, 32'h5555_0002);
    reg_read(1, OFF_RECV, v); check("R5 peek again", v, 32'h5555_0002);
    reg_read(1, OFF_CTRL, v); check("R5 queue kept", v, 32'h0001);
    reg_write(1, OFF_CTRL, 32'h8000);
    reg_read(1, OFF_RECV, v); check("R10 pop after enable", v, 32'h5555_0002);
    reg_read(1, OFF_RECV, v); check("R6 empty read zero", v, 32'h0);
    reg_read(1, OFF_CTRL, v); check("R6 underrun flag set", v, 32'h8105);
    reg_write(1, OFF_CTRL, 32'h8100);
    reg_read(1, OFF_CTRL, v); check("R6 underrun flag cleared", v, 32'h8005);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    reg_write(0, OFF_SYNC, 32'h0000_FFFF);
    reg_read(0, OFF_SYNC, v); check("R8 R9 A sync all ones", v, 32'hF0F0);
    reg_read(1, OFF_SYNC, v); check("R9 B sees A nibble", v, 32'h0F00);
    reg_write(1, OFF_SYNC, 32'h0000_00A5);
    reg_read(1, OFF_SYNC, v); check("R8 R9 B sync mixed", v, 32'h0FA0);
    reg_read(0, OFF_SYNC, v); check("R9 A sees B nibble", v, 32'hFAF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cross();
    t_fill();
    t_disabled();
    t_sync();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule